// File: doc/BRIEF.md
# Idle-Standby Read Power Gate

This block sits between a read-request stream and a memory cell that has an enable pin and a read-enable strobe. While the read mode input is asserted, it keeps the cell enabled and serves one-word reads through a valid/ready request channel and a valid/ready response channel. If no request arrives for a programmable number of clock cycles, the block drops the cell enable to save power. The read mode itself stays selected. The next request turns the cell back on and is held until a programmable wake-up time has passed.

Each accepted request produces a one-cycle read strobe to the cell, and the returned word is placed in a single response register. Request back-pressure: `req_ready_o` does not depend on `req_valid_i`. It is low while the cell is off or waking, while a strobe gap is being enforced, and while the response register is full and `rsp_ready_i` is low. A requester must hold `req_valid_i` and `req_addr_i` steady until it sees ready. Response back-pressure: once `rsp_valid_o` is high, it and `rsp_data_o` hold until `rsp_ready_i` is high. The strobe spacer can force an extra low cycle on the read strobe. This applies when the cell runs with the short-strobe timing selected and the guard input is set.

Top module: `cell_sleep_ctrl`

## Requirements
- R1: After reset, `cell_en_o`, `cell_re_o`, `req_ready_o` and `rsp_valid_o` are all 0.
- R2: When `rd_mode_i` is first sampled high with the cell off, `cell_en_o` is 1 in the next cycle. `req_ready_o` then stays 0 for exactly `wake_len_i`+1 cycles of enable before it rises.
- R3: With `idle_limit_i` = L (L > 0), the cell is enabled and idle when no request is presented and no strobe is in flight. After L consecutive idle cycles, `cell_en_o` goes to 0 in the following cycle. `req_ready_o` stays 0 while the cell is in standby.
- R4: With `idle_limit_i` = 0, the cell never enters standby while `rd_mode_i` stays high, even after more than 1023 idle cycles.
- R5: An accepted request restarts the idle count from zero. A cycle with a request presented but not accepted does not count as idle.
- R6: A request presented while in standby raises `cell_en_o` in the next cycle. The request sees `req_ready_o` low for `wake_len_i`+2 cycles, counting the cycle it was first presented, and is then accepted.
- R7: A request accepted in cycle c drives `cell_re_o` high for exactly cycle c+1, with `cell_addr_o` equal to the request address. `rsp_valid_o` is high from cycle c+2, with `rsp_data_o` equal to the `cell_rdata_i` value seen during c+1.
- R8: `cell_re_o` is never high in two adjacent cycles. When both `re_guard_i` and `strobe_fast_i` are 1, there are at least two low cycles between strobes. With `strobe_fast_i` = 0, the guard bit has no effect and back-to-back requests strobe every second cycle.
- R9: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, `rsp_valid_o` and `rsp_data_o` hold and `req_ready_o` is 0. In the cycle `rsp_ready_i` rises, `req_ready_o` may be 1.
- R10: When `rd_mode_i` goes low and no strobe is in flight, `cell_en_o` and `req_ready_o` are 0 from the next cycle. Requests then do not enable the cell.
- R11: `cell_re_o` is only high while `cell_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_mode_i | input | 1 | Direct-read mode selected |
| idle_limit_i | input | IDLE_W (10) | Idle cycles before standby; 0 disables standby |
| wake_len_i | input | WAKE_W (8) | Wake-up wait minus one, in cycles |
| strobe_fast_i | input | 1 | Short-strobe cell timing selected |
| re_guard_i | input | 1 | Request two-cycle minimum strobe low time |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Read request accepted this cycle when valid |
| req_addr_i | input | ADDR_W (13) | Read word address |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_data_o | output | DATA_W (32) | Response word |
| cell_en_o | output | 1 | Cell enable |
| cell_re_o | output | 1 | Cell read strobe |
| cell_addr_o | output | ADDR_W (13) | Cell address |
| cell_rdata_i | input | DATA_W (32) | Cell read data, valid while strobed |

## Verification
The hardest situation to reach is an idle count that is partly used when a request lands. The standby point must then be measured from the accept, not from the earlier idle cycles. The stimulus runs a few idle cycles under a known threshold and then issues a read. It counts the enabled cycles that follow and compares them with the full threshold. The guard spacing is the other hard case, because it only shows when requests arrive back to back. A request is held valid continuously under each guard/timing pairing, and the smallest gap between strobes is recorded.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    CS_OFF   = 2'd0,
    CS_WAKE  = 2'd1,
    CS_ON    = 2'd2,
    CS_SLEEP = 2'd3
  } cell_state_e;
endpackage

// File: rtl/csc_idle_timer.sv
module csc_idle_timer #(
  parameter int IDLE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [IDLE_W-1:0] limit_i,
  output logic              expire_o
);
  localparam int CW = IDLE_W + 1;

  logic [IDLE_W-1:0] cnt_q;
  logic [CW-1:0]     next_cnt;
  logic              armed;

  assign armed    = (limit_i != '0);
  assign next_cnt = {1'b0, cnt_q} + CW'(1);
  assign expire_o = tick_i && armed && (next_cnt == {1'b0, limit_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i || !armed) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= next_cnt[IDLE_W-1:0];
    end
  end
endmodule

// File: rtl/csc_wake_timer.sv
module csc_wake_timer #(
  parameter int WAKE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [WAKE_W-1:0] len_i,
  output logic              done_o
);
  logic [WAKE_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run_i && !done_o) begin
      cnt_q <= cnt_q + WAKE_W'(1);
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/csc_re_spacer.sv
module csc_re_spacer #(
  parameter bit GUARD_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic guard_i,
  output logic re_o,
  output logic open_o
);
  logic re_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) re_q <= 1'b0;
    else        re_q <= fire_i;
  end

  assign re_o = re_q;

  generate
    if (GUARD_EN) begin : g_guard
      logic re_d1_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) re_d1_q <= 1'b0;
        else        re_d1_q <= re_q;
      end
      assign open_o = !re_q && !(guard_i && re_d1_q);
    end else begin : g_plain
      assign open_o = !re_q;
    end
  endgenerate
endmodule

// File: rtl/cell_sleep_ctrl.sv
module cell_sleep_ctrl
  import csc_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 32,
  parameter int IDLE_W   = 10,
  parameter int WAKE_W   = 8,
  parameter bit GUARD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_mode_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  input  logic [WAKE_W-1:0] wake_len_i,
  input  logic              strobe_fast_i,
  input  logic              re_guard_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              cell_en_o,
  output logic              cell_re_o,
  output logic [ADDR_W-1:0] cell_addr_o,
  input  logic [DATA_W-1:0] cell_rdata_i
);
  cell_state_e state_q, state_d;

  logic              accept;
  logic              gap_open;
  logic              guard_eff;
  logic              idle_tick;
  logic              idle_clr;
  logic              idle_expire;
  logic              wake_run;
  logic              wake_done;
  logic              slot_free;
  logic [ADDR_W-1:0] addr_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  // Guard only matters with the short-strobe timing selected.
  assign guard_eff = re_guard_i && strobe_fast_i;

  assign slot_free   = !rsp_valid_q || rsp_ready_i;
  assign req_ready_o = rd_mode_i && (state_q == CS_ON) && gap_open && slot_free;
  assign accept      = req_valid_i && req_ready_o;

  csc_re_spacer #(
    .GUARD_EN (GUARD_EN)
  ) u_spacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (accept),
    .guard_i (guard_eff),
    .re_o    (cell_re_o),
    .open_o  (gap_open)
  );

  // Idle = enabled, nothing presented, no strobe in flight.
  assign idle_tick = (state_q == CS_ON) && !req_valid_i && !cell_re_o;
  assign idle_clr  = accept || (state_q != CS_ON);

  csc_idle_timer #(
    .IDLE_W (IDLE_W)
  ) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (idle_clr),
    .tick_i   (idle_tick),
    .limit_i  (idle_limit_i),
    .expire_o (idle_expire)
  );

  assign wake_run = (state_q == CS_WAKE);

  csc_wake_timer #(
    .WAKE_W (WAKE_W)
  ) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (wake_run),
    .len_i  (wake_len_i),
    .done_o (wake_done)
  );

  always_comb begin
    state_d = state_q;
    if (!rd_mode_i && !cell_re_o) begin
      state_d = CS_OFF;
    end else begin
      unique case (state_q)
        CS_OFF:   if (rd_mode_i)   state_d = CS_WAKE;
        CS_WAKE:  if (wake_done)   state_d = CS_ON;
        CS_ON:    if (idle_expire) state_d = CS_SLEEP;
        CS_SLEEP: if (req_valid_i) state_d = CS_WAKE;
        default:                   state_d = CS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_OFF;
    else        state_q <= state_d;
  end

  assign cell_en_o = (state_q == CS_WAKE) || (state_q == CS_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr_i;
  end

  assign cell_addr_o = addr_q;

  // Single response slot, filled in the strobe cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (cell_re_o) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= cell_rdata_i;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_mode_i,
  input logic              strobe_fast_i,
  input logic              re_guard_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              cell_en_o,
  input logic              cell_re_o,
  input logic [ADDR_W-1:0] cell_addr_o
);
  p_wake_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_en_o) |-> !req_ready_o);

  p_ready_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> cell_en_o);

  p_accept_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (cell_re_o && rsp_valid_o == 1'b0) or cell_re_o);

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cell_re_o |=> !cell_re_o);

  p_guard_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cell_re_o) && re_guard_i && strobe_fast_i) |-> !req_ready_o);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  p_no_accept_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o);

  p_mode_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_mode_i && !cell_re_o) |=> !cell_en_o);

  p_strobe_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cell_re_o |-> cell_en_o);

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cell_re_o |=> $stable(cell_addr_o));
endmodule

bind cell_sleep_ctrl csc_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_mode_i     (rd_mode_i),
  .strobe_fast_i (strobe_fast_i),
  .re_guard_i    (re_guard_i),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_ready_i   (rsp_ready_i),
  .rsp_data_o    (rsp_data_o),
  .cell_en_o     (cell_en_o),
  .cell_re_o     (cell_re_o),
  .cell_addr_o   (cell_addr_o)
);

// File: tb/sim_cell_sleep_ctrl.sv
module sim_cell_sleep_ctrl;
  localparam int AW = 13;
  localparam int DW = 32;
  localparam int IW = 10;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          rd_mode = 1'b0;
  logic [IW-1:0] idle_limit = '0;
  logic [WW-1:0] wake_len = 8'd3;
  logic          fast = 1'b0;
  logic          guard = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          cell_en;
  logic          cell_re;
  logic [AW-1:0] cell_addr;
  logic [DW-1:0] cell_rdata;

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return {~a, 6'h2B, a};
  endfunction

  assign cell_rdata = model(cell_addr);

  cell_sleep_ctrl u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_mode_i     (rd_mode),
    .idle_limit_i  (idle_limit),
    .wake_len_i    (wake_len),
    .strobe_fast_i (fast),
    .re_guard_i    (guard),
    .req_valid_i   (req_valid),
    .req_ready_o   (req_ready),
    .req_addr_i    (req_addr),
    .rsp_valid_o   (rsp_valid),
    .rsp_ready_i   (rsp_ready),
    .rsp_data_o    (rsp_data),
    .cell_en_o     (cell_en),
    .cell_re_o     (cell_re),
    .cell_addr_o   (cell_addr),
    .cell_rdata_i  (cell_rdata)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic read_one(input logic [AW-1:0] a, output int stall, output logic en_first);
    req_addr  = a;
    req_valid = 1'b1;
    #1;
    stall    = 0;
    en_first = cell_en;
    while (!req_ready && stall < 300) begin
      stall++;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "strobe", 32'(cell_re), 32'd1);
    chk("R7", "cell addr", 32'(cell_addr), 32'(a));
    @(negedge clk);
    chk("R7", "strobe ends", 32'(cell_re), 32'd0);
    chk("R7", "rsp valid", 32'(rsp_valid), 32'd1);
    chk("R7", "rsp data", rsp_data, model(a));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "en", 32'(cell_en), 32'd0);
    chk("R1", "re", 32'(cell_re), 32'd0);
    chk("R1", "ready", 32'(req_ready), 32'd0);
    chk("R1", "rsp valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_enter(input int w);
    int n;
    wake_len = WW'(w);
    rd_mode  = 1'b1;
    @(negedge clk);
    chk("R2", "en after mode", 32'(cell_en), 32'd1);
    n = 0;
    while (!req_ready && n < 300) begin
      n++;
      @(negedge clk);
    end
    chk("R2", "wake stall cycles", 32'(n), 32'(w + 1));
  endtask

  task automatic t_read_basic();
    int s;
    logic e;
    read_one(13'h0A5, s, e);
    chk("R7", "stall when on", 32'(s), 32'd0);
    @(negedge clk);
    chk("R7", "rsp drained", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_spacing(input logic g, input logic f, input int exp_gap);
    int gap;
    int min_gap;
    int pulses;
    bit seen;
    guard = g;
    fast  = f;
    req_addr  = 13'h111;
    req_valid = 1'b1;
    min_gap = 1000;
    pulses  = 0;
    gap     = 0;
    seen    = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (cell_re) begin
        if (seen && gap < min_gap) min_gap = gap;
        seen = 1'b1;
        gap  = 0;
        pulses++;
      end else begin
        gap++;
      end
    end
    req_valid = 1'b0;
    chk("R8", "strobe count", 32'(pulses >= 4), 32'd1);
    chk("R8", "min strobe gap", 32'(min_gap), 32'(exp_gap));
    repeat (4) @(negedge clk);
    guard = 1'b0;
    fast  = 1'b0;
  endtask

  task automatic t_no_sleep();
    idle_limit = '0;
    repeat (1100) @(negedge clk);
    chk("R4", "en after long idle", 32'(cell_en), 32'd1);
    chk("R4", "ready after long idle", 32'(req_ready), 32'd1);
  endtask

  task automatic t_sleep(input int l);
    int n;
    idle_limit = IW'(l);
    n = 0;
    while (cell_en && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk("R3", "enabled idle cycles", 32'(n), 32'(l));
    chk("R3", "ready in standby", 32'(req_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R3", "stays in standby", 32'(cell_en), 32'd0);
  endtask

  task automatic t_wake_req(input int w);
    int s;
    logic e;
    wake_len = WW'(w);
    read_one(13'h1C3, s, e);
    chk("R6", "en before wake", 32'(e), 32'd0);
    chk("R6", "wake stall cycles", 32'(s), 32'(w + 2));
  endtask

  task automatic t_idle_reset(input int l);
    int s;
    int n;
    logic e;
    idle_limit = IW'(l);
    repeat (3) @(negedge clk);
    read_one(13'h0F0, s, e);
    chk("R5", "stall mid count", 32'(s), 32'd0);
    n = 0;
    while (cell_en && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk("R5", "idle count restarted", 32'(n), 32'(l));
  endtask

  task automatic t_backpressure(input int w);
    int s;
    logic e;
    logic [DW-1:0] held;
    idle_limit = '0;
    rsp_ready  = 1'b0;
    read_one(13'h0777, s, e);
    chk("R6", "wake stall before hold", 32'(s), 32'(w + 2));
    held = rsp_data;
    req_addr  = 13'h0222;
    req_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R9", "ready while full", 32'(req_ready), 32'd0);
      chk("R9", "rsp held", 32'(rsp_valid), 32'd1);
      chk("R9", "data held", rsp_data, held);
      chk("R9", "no strobe", 32'(cell_re), 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    #1;
    chk("R9", "ready on drain", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "strobe after drain", 32'(cell_re), 32'd1);
    chk("R9", "slot emptied", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R9", "second rsp", rsp_data, model(13'h0222));
    @(negedge clk);
  endtask

  task automatic t_leave();
    rd_mode = 1'b0;
    @(negedge clk);
    chk("R10", "en off", 32'(cell_en), 32'd0);
    chk("R10", "ready off", 32'(req_ready), 32'd0);
    req_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10", "request ignored", 32'(cell_en), 32'd0);
    end
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_enter(3);
    t_read_basic();
    t_spacing(1'b0, 1'b0, 1);
    t_spacing(1'b1, 1'b0, 1);
    t_spacing(1'b1, 1'b1, 2);
    t_no_sleep();
    t_sleep(5);
    t_wake_req(2);
    t_idle_reset(6);
    t_backpressure(2);
    t_leave();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule